// File: doc/BRIEF.md
# Programmable FIFO Flag Offset Loader

This block holds the two threshold offsets a FIFO compares against its fill level to raise almost-empty and almost-full flags. Each offset is `OFS_W` bits wide (16 by default, 17 as the alternative). The block stores each offset as a short chain of byte-wide registers: two per offset at 16 bits, three at 17 bits. In the 17-bit case the top register of each offset holds only one bit.

Software or a controller programs the offsets in one of two ways, chosen once at master reset. In parallel mode one byte per write-clock edge arrives on a 9-bit bus, and a rotating pointer walks the registers. In serial mode one bit is shifted in per write-clock edge. A parallel read path with its own rotating pointer returns the registers one byte at a time on the read clock, in either mode.

The level of the configuration strobe during master reset picks one of two sets of default offsets. When that strobe is high, the block passes the write and read enables through to the FIFO memory instead.

Top module: `fifo_ofs_loader`

## Requirements
- R1: With `cfg_n` low during master reset, both offsets reset to 0x7F: low register 7FH, every higher register 00H.
- R2: With `cfg_n` high during master reset, both offsets reset to 0x3FF: low register FFH, second register 03H, any top register 0.
- R3: In parallel mode, each write-clock edge with `cfg_n` low and `wr_n` low stores `data_in[7:0]` in the register the write pointer selects. The pointer then advances in this order: empty low, empty upper register(s), full low, full upper register(s). After the last register it wraps to the first. The new value shows on the offset outputs after that edge.
- R4: Each read-clock edge with `cfg_n` low and `rd_n` low loads `data_out` with {1'b0, register}. A separate read pointer selects the register and follows the same order and wrap as R3. Otherwise `data_out` holds its value.
- R5: Parallel reads work in serial mode as well as in parallel mode.
- R6: In serial mode, each write-clock edge with `cfg_n` low and `shift_n` low shifts `ser_in` into the chain {full, empty}. The new bit enters at the top of the full offset and every bit moves down one place. After 2×`OFS_W` shifts, the first bit sits in empty bit 0 and the last bit in full bit `OFS_W`-1.
- R7: `shift_n` low during master reset selects serial mode; high selects parallel mode. The mode holds until the next master reset. Register writes are ignored in serial mode and shifts are ignored in parallel mode.
- R8: With `cfg_n` high, `mem_wr` = !`wr_n` and `mem_rd` = !`rd_n`. The offsets and both pointers do not change.
- R9: With `OFS_W` = 17, the top register of each offset stores only `data_in[0]`, and it reads back as 0000000 plus that bit.
- R10: Master reset returns both the write pointer and the read pointer to the empty low register.
- R11: `mem_wr` and `mem_rd` stay low while `cfg_n` is low or master reset is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock: register writes, shifts, master reset |
| rd_clk | input | 1 | Read clock: parallel register reads |
| master_rst | input | 1 | Synchronous master reset, active high |
| cfg_n | input | 1 | Low: register access; high: memory access; level at reset picks defaults |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| shift_n | input | 1 | Shift strobe, active low; level at reset picks the mode |
| ser_in | input | 1 | Serial data bit |
| data_in | input | 9 | Parallel register write data |
| empty_ofs | output | OFS_W | Almost-empty offset |
| full_ofs | output | OFS_W | Almost-full offset |
| data_out | output | 9 | Parallel register read data |
| mem_wr | output | 1 | FIFO memory write enable |
| mem_rd | output | 1 | FIFO memory read enable |

## Verification
The hardest case to reach is the rotating pointers at their wrap points when writes and reads interleave in one run. The same applies to serial mode, which can only be entered through a master reset. Random streams mix strobes and configuration levels across many master resets in both modes, so the pointers pass their wraps repeatedly. A 16-bit and a 17-bit instance receive the same stimulus. Directed sequences add a full 34-bit serial load, a pointer reset from mid-chain, and read sweeps longer than the chain.

// File: rtl/fifo_ofs_loader.sv
module fifo_ofs_loader #(
  parameter int OFS_W = 16
) (
  input  logic             wr_clk,
  input  logic             rd_clk,
  input  logic             master_rst,
  input  logic             cfg_n,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             shift_n,
  input  logic             ser_in,
  input  logic [8:0]       data_in,
  output logic [OFS_W-1:0] empty_ofs,
  output logic [OFS_W-1:0] full_ofs,
  output logic [8:0]       data_out,
  output logic             mem_wr,
  output logic             mem_rd
);

  localparam int NB   = (OFS_W + 7) / 8;
  localparam int NREG = 2 * NB;
  localparam int CW   = 2 * OFS_W;
  localparam int PW   = $clog2(NREG);
  localparam logic [PW-1:0] LAST = PW'(NREG - 1);
  localparam logic [OFS_W-1:0] DFLT_LO = OFS_W'(16'h007F);
  localparam logic [OFS_W-1:0] DFLT_HI = OFS_W'(16'h03FF);

  function automatic int reg_of(input int b);
    return (b / OFS_W) * NB + (b % OFS_W) / 8;
  endfunction

  function automatic int pos_of(input int b);
    return (b % OFS_W) % 8;
  endfunction

  logic [CW-1:0] chain_q, chain_d;
  logic [PW-1:0] wptr_q, rptr_q;
  logic          serial_q;
  logic [7:0]    rd_byte;
  logic          unused_bit8;

  assign unused_bit8 = data_in[8];

  wire reg_wr = !master_rst && !cfg_n && !wr_n && !serial_q;
  wire reg_sh = !master_rst && !cfg_n && !shift_n && serial_q;
  wire reg_rd = !master_rst && !cfg_n && !rd_n;

  assign mem_wr    = !master_rst && cfg_n && !wr_n;
  assign mem_rd    = !master_rst && cfg_n && !rd_n;
  assign empty_ofs = chain_q[OFS_W-1:0];
  assign full_ofs  = chain_q[CW-1:OFS_W];

  always_comb begin
    chain_d = chain_q;
    if (reg_sh) begin
      chain_d = {ser_in, chain_q[CW-1:1]};
    end else if (reg_wr) begin
      for (int b = 0; b < CW; b++)
        if (reg_of(b) == int'(wptr_q)) chain_d[b] = data_in[pos_of(b)];
    end
  end

  always_ff @(posedge wr_clk) begin
    if (master_rst) begin
      chain_q  <= cfg_n ? {DFLT_HI, DFLT_HI} : {DFLT_LO, DFLT_LO};
      wptr_q   <= '0;
      serial_q <= !shift_n;
    end else begin
      chain_q <= chain_d;
      if (reg_wr) wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
    end
  end

  always_comb begin
    rd_byte = '0;
    for (int b = 0; b < CW; b++)
      if (reg_of(b) == int'(rptr_q)) rd_byte[pos_of(b)] = chain_q[b];
  end

  always_ff @(posedge rd_clk) begin
    if (master_rst) begin
      rptr_q   <= '0;
      data_out <= '0;
    end else if (reg_rd) begin
      data_out <= {1'b0, rd_byte};
      rptr_q   <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
    end
  end

  a_r7_mode_fixed: assert property (@(posedge wr_clk) disable iff (master_rst)
    !cfg_n || cfg_n |=> $stable(serial_q));
  a_r8_cfg_hold: assert property (@(posedge wr_clk) disable iff (master_rst)
    cfg_n |=> $stable(chain_q) && $stable(wptr_q));
  a_r7_write_ignored: assert property (@(posedge wr_clk) disable iff (master_rst)
    (serial_q && !cfg_n && !wr_n && shift_n) |=> $stable(chain_q) && $stable(wptr_q));
  a_r7_shift_ignored: assert property (@(posedge wr_clk) disable iff (master_rst)
    (!serial_q && !cfg_n && !shift_n && wr_n) |=> $stable(chain_q));
  a_r3_wptr_moves: assert property (@(posedge wr_clk) disable iff (master_rst)
    reg_wr |=> wptr_q != $past(wptr_q));
  a_r11_mem_quiet: assert property (@(posedge wr_clk) disable iff (master_rst)
    !cfg_n |-> !mem_wr && !mem_rd);
  a_r4_rd_hold: assert property (@(posedge rd_clk) disable iff (master_rst)
    !reg_rd |=> $stable(data_out) && $stable(rptr_q));

endmodule

// File: tb/fifo_ofs_loader_tb_top.sv
module fifo_ofs_loader_tb_top;
  localparam int CLK_P = 10;

  logic clk = 0, master_rst = 1, cfg_n = 0, wr_n = 1, rd_n = 1, shift_n = 1, ser_in = 0;
  logic [8:0]  data_in = '0;
  logic [15:0] e16, f16;
  logic [16:0] e17, f17;
  logic [8:0]  do16, do17;
  logic mw16, mr16, mw17, mr17;

  always #(CLK_P/2) clk = ~clk;

  fifo_ofs_loader #(.OFS_W(16)) dut_i (
    .wr_clk(clk), .rd_clk(clk), .master_rst(master_rst), .cfg_n(cfg_n), .wr_n(wr_n),
    .rd_n(rd_n), .shift_n(shift_n), .ser_in(ser_in), .data_in(data_in),
    .empty_ofs(e16), .full_ofs(f16), .data_out(do16), .mem_wr(mw16), .mem_rd(mr16));

  fifo_ofs_loader #(.OFS_W(17)) dut17_i (
    .wr_clk(clk), .rd_clk(clk), .master_rst(master_rst), .cfg_n(cfg_n), .wr_n(wr_n),
    .rd_n(rd_n), .shift_n(shift_n), .ser_in(ser_in), .data_in(data_in),
    .empty_ofs(e17), .full_ofs(f17), .data_out(do17), .mem_wr(mw17), .mem_rd(mr17));

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  string cur_req = "R1";
  logic [31:0] c16;
  logic [33:0] c17;
  int wp16, wp17, rp16, rp17;
  bit ser_mode;
  logic [8:0] x16, x17;

  function automatic logic [7:0] byte16(input logic [31:0] c, input int k);
    return c[(k/2)*16 + (k%2)*8 +: 8];
  endfunction

  function automatic logic [7:0] byte17(input logic [33:0] c, input int k);
    if (k % 3 == 2) return {7'b0, c[(k/3)*17 + 16]};
    return c[(k/3)*17 + (k%3)*8 +: 8];
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_ofs();
    check({f16, e16} === c16, cur_req, 64'({f16, e16}), 64'(c16));
    check({f17, e17} === c17, "R9", 64'({f17, e17}), 64'(c17));
    check(do16 === x16, "R4", 64'(do16), 64'(x16));
    check(do17 === x17, "R4", 64'(do17), 64'(x17));
  endtask

  task automatic do_reset(input logic cf, input logic s);
    master_rst = 1; cfg_n = cf; shift_n = s; wr_n = 1; rd_n = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    master_rst = 0; shift_n = 1;
    c16 = cf ? {16'h03FF, 16'h03FF} : {16'h007F, 16'h007F};
    c17 = cf ? {17'h003FF, 17'h003FF} : {17'h0007F, 17'h0007F};
    wp16 = 0; wp17 = 0; rp16 = 0; rp17 = 0; ser_mode = !s; x16 = '0; x17 = '0;
    #1 check_ofs();
  endtask

  task automatic step(input logic cf, input logic w, input logic r, input logic s,
                      input logic sd, input logic [8:0] d);
    cfg_n = cf; wr_n = w; rd_n = r; shift_n = s; ser_in = sd; data_in = d;
    #1;
    check(mw16 === (cf && !w) && mw17 === mw16, "R8 R11", 64'(mw16), 64'(cf && !w));
    check(mr16 === (cf && !r) && mr17 === mr16, "R8 R11", 64'(mr16), 64'(cf && !r));
    @(posedge clk);
    if (!cf && !r) begin
      x16 = {1'b0, byte16(c16, rp16)}; rp16 = (rp16 + 1) % 4;
      x17 = {1'b0, byte17(c17, rp17)}; rp17 = (rp17 + 1) % 6;
    end
    if (!cf && !w && !ser_mode) begin
      c16[(wp16/2)*16 + (wp16%2)*8 +: 8] = d[7:0];
      if (wp17 % 3 == 2) c17[(wp17/3)*17 + 16] = d[0];
      else c17[(wp17/3)*17 + (wp17%3)*8 +: 8] = d[7:0];
      wp16 = (wp16 + 1) % 4; wp17 = (wp17 + 1) % 6;
    end
    if (!cf && !s && ser_mode) begin
      c16 = {sd, c16[31:1]};
      c17 = {sd, c17[33:1]};
    end
    @(negedge clk);
    check_ofs();
  endtask

  task automatic rand_ops(input int n);
    for (int i = 0; i < n; i++)
      step(($urandom % 4) == 0, $urandom % 2, $urandom % 2, $urandom % 2,
           $urandom % 2, 9'($urandom));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [33:0] pat;
    void'($urandom(32'h5EED1));
    @(negedge clk);
    cur_req = "R1"; do_reset(0, 1);
    cur_req = "R4"; for (int i = 0; i < 7; i++) step(0, 1, 0, 1, 0, '0);
    cur_req = "R3";
    for (int i = 0; i < 7; i++) step(0, 0, 1, 1, 0, 9'(8'h11 * (i + 1)) | 9'h100);
    for (int i = 0; i < 7; i++) step(0, 1, 0, 1, 0, '0);
    cur_req = "R7"; for (int i = 0; i < 4; i++) step(0, 1, 1, 0, 1, '0);
    cur_req = "R8"; for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 1, 9'h0AA);
    cur_req = "R3"; rand_ops(400);
    cur_req = "R10";
    step(0, 0, 0, 1, 0, 9'h033);
    do_reset(0, 1);
    step(0, 0, 0, 1, 0, 9'h0A5);
    step(0, 1, 0, 1, 0, '0);
    cur_req = "R2"; do_reset(1, 1);
    for (int i = 0; i < 6; i++) step(0, 1, 0, 1, 0, '0);
    rand_ops(300);
    cur_req = "R6"; do_reset(0, 0);
    pat = 34'h2_C3A5_9E17;
    for (int i = 0; i < 34; i++) step(0, 1, 1, 0, pat[i], '0);
    check({f17, e17} === pat, "R6", 64'({f17, e17}), 64'(pat));
    check({f16, e16} === pat[33:2], "R6", 64'({f16, e16}), 64'(pat[33:2]));
    cur_req = "R5"; for (int i = 0; i < 7; i++) step(0, 1, 0, 1, 0, '0);
    cur_req = "R7"; for (int i = 0; i < 5; i++) step(0, 0, 1, 1, 0, 9'h1FF);
    rand_ops(400);
    cur_req = "R2"; do_reset(1, 0);
    cur_req = "R7"; rand_ops(300);
    cur_req = "R1"; do_reset(0, 1);
    cur_req = "R3"; rand_ops(300);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule